// File: doc/BRIEF.md
# Two-Stage Timer Tick Generator

This block turns the peripheral clock into one tick enable per timer for a bank of timers. The timers are split into two groups. Each group has its own 8-bit programmable prescaler and its own external clock pin. Each timer then divides its group's prescaler ticks by 2, 4, 8 or 16. Instead of that, a timer can take a tick from every rising edge of its group's external pin. The pin is first passed through a synchronizer.

Every output is an enable pulse one peripheral clock wide, in the peripheral clock domain. No derived clock is produced. A timer counter that sits downstream advances on each pulse. The prescaler values and the per-timer source selects are static configuration inputs. Changing a prescaler value restarts that group's prescale count.

Top module: `timer_tick_gen`

## Requirements
- R1: While `rst_n` is low, every `tick` output is 0.
- R2: A prescaler value P makes its group's prescaler pulse once every P+1 clocks. P = 0 pulses on every clock, and P = 255 pulses every 256 clocks.
- R3: For select code 000, 001, 010 or 011 (3 bits per timer, timer i at `src_sel[3i+2:3i]`), consecutive ticks of a timer are (P+1) * 2, 4, 8 or 16 clocks apart.
- R4: Each timer has its own second-stage divider. Timers that share a prescaler but have different codes tick at their own rates at the same time.
- R5: Timers 0 and 1 use `pscale_a` and `ext_clk_a`. Timers 2 to 4 use `pscale_b` and `ext_clk_b`. One group's inputs have no effect on the other group's ticks.
- R6: Select code 100 gives one tick per rising edge of the group's external pin. The tick is high in the clock cycle after the third rising clock edge at which the pin is sampled, counting from the first edge that samples it high. A falling edge gives no tick.
- R7: Select codes 101, 110 and 111 produce no ticks.
- R8: Each tick is high for exactly one clock cycle.
- R9: A change of prescaler value restarts the prescale count. From the second tick after the change onward, tick spacing matches the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pscale_a | input | 8 | Prescaler value for timers 0 and 1 |
| pscale_b | input | 8 | Prescaler value for timers 2 to 4 |
| src_sel | input | 15 | Per-timer source select, 3 bits per timer |
| ext_clk_a | input | 1 | External clock pin for timers 0 and 1 |
| ext_clk_b | input | 1 | External clock pin for timers 2 to 4 |
| tick | output | 5 | One-cycle tick enable per timer |

## Verification
The divider path is run with prescaler values 0, 2, 4 and 255, with all four divide codes spread over timers of both groups. The measured spacing of ticks separates a wrong prescale count (off by one) from a wrong divider tap, and it catches one group using the other group's prescaler. A prescaler change in mid-run checks that the count restarts and that the new ratio then holds. The external path is driven with a single rising edge to fix its exact latency, with a long high level followed by a fall to show that a falling edge is ignored, and with a burst of pulses on one pin while timers on both pins listen, which shows the groups are kept apart. The reserved codes are held for a long window and must give no ticks at all.

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
  parameter int PRE_W     = 8,
  parameter int NUM_TMR   = 5,
  parameter int GRP_A_CNT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PRE_W-1:0]     pscale_a,
  input  logic [PRE_W-1:0]     pscale_b,
  input  logic [3*NUM_TMR-1:0] src_sel,
  input  logic                 ext_clk_a,
  input  logic                 ext_clk_b,
  output logic [NUM_TMR-1:0]   tick
);

  localparam int SEL_W = 3;
  localparam int DIV_W = 4;

  logic [1:0] pre_pulse;
  logic [1:0] ext_pulse;

  for (genvar g = 0; g < 2; g++) begin : gen_grp
    logic [PRE_W-1:0] pv, pv_q, pcnt;
    logic             ext_in;
    logic [2:0]       sync;

    assign pv     = (g == 0) ? pscale_a : pscale_b;
    assign ext_in = (g == 0) ? ext_clk_a : ext_clk_b;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pv_q <= '0;
        pcnt <= '0;
        sync <= '0;
      end else begin
        pv_q <= pv;
        pcnt <= (pv != pv_q || pcnt == pv) ? '0 : pcnt + 1'b1;
        sync <= {sync[1:0], ext_in};
      end
    end

    assign pre_pulse[g] = (pv == pv_q) && (pcnt == pv);
    assign ext_pulse[g] = sync[1] & ~sync[2];
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : gen_tmr
    localparam int G = (t < GRP_A_CNT) ? 0 : 1;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] dcnt, mask;
    logic             div_hit, tick_q;

    assign sel = src_sel[SEL_W*t +: SEL_W];

    always_comb begin
      case (sel[1:0])
        2'd0:    mask = 4'b0001;
        2'd1:    mask = 4'b0011;
        2'd2:    mask = 4'b0111;
        default: mask = 4'b1111;
      endcase
    end

    assign div_hit = &(dcnt | ~mask);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dcnt   <= '0;
        tick_q <= 1'b0;
      end else begin
        if (pre_pulse[G]) dcnt <= dcnt + 1'b1;
        if (sel == 3'd4)  tick_q <= ext_pulse[G];
        else              tick_q <= !sel[2] && pre_pulse[G] && div_hit;
      end
    end

    assign tick[t] = tick_q;
  end

endmodule

module timer_tick_gen_chk #(
  parameter int NUM_TMR   = 5,
  parameter int GRP_A_CNT = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3*NUM_TMR-1:0] src_sel,
  input logic                 ext_clk_a,
  input logic                 ext_clk_b,
  input logic [NUM_TMR-1:0]   tick
);

  logic [2:0] age;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end
  assign armed = (age >= 3'd5);

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (tick == '0); // R1
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : gen_chk
    logic e;
    assign e = (t < GRP_A_CNT) ? ext_clk_a : ext_clk_b;

    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel[3*t +: 3] > 3'd4) |=> !tick[t]); // R7

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[t] && $stable(src_sel[3*t +: 3])) |=> !tick[t]); // R8

    AST_EXT_EDGE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(src_sel[3*t +: 3]) == 3'd4 && $past(e, 3) && !$past(e, 4))
      |-> tick[t]); // R6
  end

endmodule

bind timer_tick_gen timer_tick_gen_chk #(.NUM_TMR(NUM_TMR), .GRP_A_CNT(GRP_A_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
  .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b), .tick(tick)
);

// File: tb/timer_tick_gen_tb.sv
`timescale 1ns/1ps
module timer_tick_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pscale_a = 8'd0, pscale_b = 8'd0;
  logic [14:0] src_sel = '0;
  logic        ext_clk_a = 1'b0, ext_clk_b = 1'b0;
  logic [4:0]  tick;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  timer_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .pscale_a(pscale_a), .pscale_b(pscale_b),
    .src_sel(src_sel), .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b), .tick(tick)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_sel(input int t, input logic [2:0] code);
    src_sel[3*t +: 3] = code;
  endtask

  task automatic wait_tick(input int t);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (tick[t]) return;
    end
  endtask

  task automatic interval(input int t, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick[t] && n < 6000);
  endtask

  task automatic measure(input string req, input int t, input int exp, input int skip);
    int n;
    for (int s = 0; s < skip; s++) wait_tick(t);
    wait_tick(t);
    for (int k = 0; k < 2; k++) begin
      interval(t, n);
      check(req, n, exp);
    end
  endtask

  task automatic t_reset;
    int hits = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tick != '0) hits++;
    end
    check("R1 ticks during reset", hits, 0);
  endtask

  task automatic t_div_basic;
    pscale_a = 0; set_sel(0, 3'd0);
    measure("R2 R3 P=0 code000", 0, 2, 1);
    pscale_a = 2; set_sel(0, 3'd1); set_sel(1, 3'd3);
    measure("R4 timer0 P=2 code001", 0, 12, 2);
    measure("R4 timer1 P=2 code011", 1, 48, 1);
  endtask

  task automatic t_group_b;
    pscale_b = 4; pscale_a = 7;
    set_sel(2, 3'd2); set_sel(3, 3'd0); set_sel(4, 3'd3);
    measure("R3 R5 timer2 P=4 code010", 2, 40, 2);
    measure("R3 R5 timer3 P=4 code000", 3, 10, 1);
    measure("R3 R5 timer4 P=4 code011", 4, 80, 1);
  endtask

  task automatic t_max_prescale;
    pscale_a = 255; set_sel(1, 3'd3);
    measure("R2 P=255 code011", 1, 4096, 2);
  endtask

  task automatic t_change;
    pscale_a = 2; set_sel(0, 3'd0);
    measure("R9 before change", 0, 6, 2);
    @(negedge clk); pscale_a = 5;
    measure("R9 after change", 0, 12, 1);
  endtask

  task automatic t_width;
    int dbl = 0, prev = 0, cnt = 0;
    pscale_a = 0; set_sel(0, 3'd0);
    pscale_b = 0; set_sel(2, 3'd0);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tick[0] && prev) dbl++;
      if (tick[2]) cnt++;
      prev = tick[0];
    end
    check("R8 back-to-back highs", dbl, 0);
    check("R8 tick count over 200 cycles at ratio 2", cnt, 100);
  endtask

  task automatic t_external;
    int c2, c0;
    set_sel(0, 3'd4); set_sel(2, 3'd4);
    ext_clk_a = 0; ext_clk_b = 0;
    repeat (8) @(negedge clk);
    ext_clk_b = 1;
    @(negedge clk); @(negedge clk);
    check("R6 no tick before latency", tick[2], 0);
    @(negedge clk);
    check("R6 tick at latency 3", tick[2], 1);
    @(negedge clk);
    check("R8 external tick width", tick[2], 0);
    c2 = 0;
    repeat (6) @(negedge clk);
    ext_clk_b = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tick[2]) c2++;
    end
    check("R6 falling edge gives no tick", c2, 0);
    c2 = 0; c0 = 0;
    for (int p = 0; p < 4; p++) begin
      ext_clk_b = 1;
      for (int i = 0; i < 3; i++) begin @(negedge clk); c2 += tick[2]; c0 += tick[0]; end
      ext_clk_b = 0;
      for (int i = 0; i < 3; i++) begin @(negedge clk); c2 += tick[2]; c0 += tick[0]; end
    end
    for (int i = 0; i < 6; i++) begin @(negedge clk); c2 += tick[2]; c0 += tick[0]; end
    check("R6 one tick per rising edge", c2, 4);
    check("R5 other group pin has no effect", c0, 0);
  endtask

  task automatic t_reserved;
    int c = 0;
    pscale_a = 0; pscale_b = 0;
    set_sel(0, 3'd5); set_sel(1, 3'd6); set_sel(2, 3'd7);
    set_sel(3, 3'd5); set_sel(4, 3'd6);
    @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      if (i % 4 == 0) begin ext_clk_a = ~ext_clk_a; ext_clk_b = ~ext_clk_b; end
      @(negedge clk);
      if (tick != '0) c++;
    end
    check("R7 reserved codes silent", c, 0);
  endtask

  initial begin
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_div_basic();
    t_group_b();
    t_max_prescale();
    t_change();
    t_width();
    t_external();
    t_reserved();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule